// File: doc/BRIEF.md
# DRAM Strobe Sequencer with CPU-Driven RAS-Only Refresh

This block sits between an 8-bit microprocessor memory bus (active-low request, read, write and refresh strobes plus a 16-bit address) and a 64K x 1 dynamic memory array whose devices have separate data-in and data-out pins. It produces the row strobe, the row/column address multiplexer and its select, and the column strobe. A short clocked tap chain, running several times faster than the bus, takes the place of an analog delay line. It also drives the boot ROM enable, the read-data buffer enable and the DRAM write enable.

Refresh needs no counter of its own. When the processor runs a refresh cycle, it places its refresh row on the low address bits. The low address byte is always routed as the row address, so that row reaches the array while only the row strobe is pulsed. A boot flag, set by reset and dropped by a clear input, sends reads to ROM and lets only writes reach DRAM. Once the flag drops, every non-refresh request cycles the array. Writes use read-modify-write timing: the write strobe arrives late, and the read buffer stays off so that DRAM output cannot collide with write data.

Top module: `dram_seq_ctrl`

## Requirements
- R1: A synchronous reset (rst high) sets the boot flag. During boot a memory read gives rom_en_n=0, rdbuf_en_n=1, ras_n=1 and cas_n=1.
- R2: boot_clear high at a rising clock edge (rst low) clears the boot flag from that edge on. Only a reset sets it again.
- R3: ramsel_n is 0 exactly when mreq_n=0 and rfsh_n=1.
- R4: ras_n is 0 for a refresh request (mreq_n=0, rfsh_n=0) in any phase. For a non-refresh request it is 0 in boot only when wr_n=0, and after boot it is 0 for every request.
- R5: During refresh, cas_n stays 1, mux_col stays 0, and dram_addr equals cpu_addr[7:0], which carries the refresh row on bits 6..0.
- R6: dram_addr is cpu_addr[7:0] while mux_col=0 and cpu_addr[15:8] while mux_col=1. In a non-refresh request mux_col is 0 when the request begins and rises MUX_TAP (default 1) clock edges later.
- R7: cas_n falls CAS_TAP (default 2) clock edges after a non-refresh request begins, for reads after boot and for writes (wr_n=0) in either phase. During a write it falls no earlier than wr_n. Boot reads never assert it.
- R8: rom_en_n is 0 only for a memory read (mreq_n=0, rd_n=0) while the boot flag is set.
- R9: rdbuf_en_n is 0 only for a memory read after boot has ended. It stays 1 during writes.
- R10: we_n equals wr_n at all times.
- R11: When mreq_n goes to 1, ras_n, cas_n, mux_col, rom_en_n and rdbuf_en_n return to their inactive levels in the same cycle. The next request starts its tap sequence from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tap-chain clock, several times the bus rate |
| rst | input | 1 | Synchronous reset, active high, sets the boot flag |
| boot_clear | input | 1 | Clears the boot flag at a clock edge |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, arrives late |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| cpu_addr | input | 16 | CPU address bus |
| dram_addr | output | 8 | Multiplexed DRAM address |
| mux_col | output | 1 | Multiplexer select, 1 = column half |
| ramsel_n | output | 1 | DRAM select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| rom_en_n | output | 1 | Boot ROM enable, active low |
| rdbuf_en_n | output | 1 | DRAM read-data buffer enable, active low |

## Verification
Two pairs of functions can fall in the same cycle. The first is a refresh that follows a DRAM read with the request held low. In the cycle rfsh_n falls, the bench checks that the column select and column strobe of the read drop at once and that the refresh row appears on dram_addr without waiting for a clock edge. The second is a boot_clear that lands in the middle of a boot-time read. The bench checks that the ROM enable hands over to the read buffer and the row strobe at the very next edge, with no cycle in which both enables are active.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Row strobe wanted for the current bus state.
  function automatic logic ras_want(input logic req, input logic wr,
                                    input logic rfsh, input logic boot);
    return req && (rfsh || wr || !boot);
  endfunction

  // Column strobe wanted, given the delayed tap.
  function automatic logic cas_want(input logic tap, input logic req,
                                    input logic rd, input logic wr,
                                    input logic rfsh, input logic boot);
    return tap && req && !rfsh && (wr || (rd && !boot));
  endfunction

  // Pick one half of the address as the DRAM address.
  function automatic logic [7:0] addr_half(input logic [15:0] a, input logic col);
    return col ? a[15:8] : a[7:0];
  endfunction

endpackage

// File: rtl/dram_boot_flag.sv
module dram_boot_flag (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic boot
);
  always_ff @(posedge clk) begin
    if (rst)        boot <= 1'b1;
    else if (clear) boot <= 1'b0;
  end
endmodule

// File: rtl/dram_tap_chain.sv
module dram_tap_chain #(
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  output logic [TAPS-1:0] taps
);
  // Each stage copies the one before; stage 0 takes the run level.
  // The whole chain empties as soon as run drops.
  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_head
      assign src = 1'b1;
    end else begin : g_body
      assign src = taps[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst || !run) taps[g] <= 1'b0;
      else             taps[g] <= src;
    end
  end
endmodule

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
  import dram_seq_pkg::*;
#(
  parameter int TAPS    = 4,
  parameter int MUX_TAP = 1,
  parameter int CAS_TAP = 2
) (
  input  logic            req,
  input  logic            rd,
  input  logic            wr,
  input  logic            rfsh,
  input  logic            boot,
  input  logic [TAPS-1:0] taps,
  output logic            ramsel,
  output logic            ras,
  output logic            col_sel,
  output logic            cas,
  output logic            rom_en,
  output logic            rdbuf_en
);
  always_comb begin
    ramsel   = req && !rfsh;
    ras      = ras_want(req, wr, rfsh, boot);
    col_sel  = ramsel && taps[MUX_TAP-1];
    cas      = cas_want(taps[CAS_TAP-1], req, rd, wr, rfsh, boot);
    rom_en   = req && rd && boot;
    rdbuf_en = req && rd && !boot;
  end
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TAPS    = 4,
  parameter int MUX_TAP = 1,
  parameter int CAS_TAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_clear,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rfsh_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic              mux_col,
  output logic              ramsel_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              rom_en_n,
  output logic              rdbuf_en_n
);
  localparam int ROW_W = ADDR_W / 2;

  // Named internal events, visible to the bound checker.
  logic            boot_q;
  logic [TAPS-1:0] tap_q;
  logic            ramsel_act, ras_act, col_act, cas_act, rom_act, rdbuf_act;

  dram_boot_flag u_boot (
    .clk   (clk),
    .rst   (rst),
    .clear (boot_clear),
    .boot  (boot_q)
  );

  dram_tap_chain #(.TAPS(TAPS)) u_taps (
    .clk  (clk),
    .rst  (rst),
    .run  (ramsel_act),
    .taps (tap_q)
  );

  dram_strobe_decode #(.TAPS(TAPS), .MUX_TAP(MUX_TAP), .CAS_TAP(CAS_TAP)) u_dec (
    .req      (!mreq_n),
    .rd       (!rd_n),
    .wr       (!wr_n),
    .rfsh     (!rfsh_n),
    .boot     (boot_q),
    .taps     (tap_q),
    .ramsel   (ramsel_act),
    .ras      (ras_act),
    .col_sel  (col_act),
    .cas      (cas_act),
    .rom_en   (rom_act),
    .rdbuf_en (rdbuf_act)
  );

  always_comb begin
    dram_addr  = col_act ? cpu_addr[ADDR_W-1:ROW_W] : cpu_addr[ROW_W-1:0];
    mux_col    = col_act;
    ramsel_n   = !ramsel_act;
    ras_n      = !ras_act;
    cas_n      = !cas_act;
    we_n       = wr_n;
    rom_en_n   = !rom_act;
    rdbuf_en_n = !rdbuf_act;
  end
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       boot_clear,
  input logic       mreq_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       rfsh_n,
  input logic [7:0] dram_addr,
  input logic       mux_col,
  input logic       ramsel_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       rom_en_n,
  input logic       rdbuf_en_n
);
  // R3: refresh never selects DRAM
  a_r3_no_sel_in_refresh: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n |-> ramsel_n);

  // R5: refresh is row strobe only, row half of the address
  a_r5_refresh_ras_only: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rfsh_n) |-> (!ras_n && cas_n && !mux_col));

  // R7: column strobe only inside a row strobe
  a_r7_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  // R6: column strobe only after the select moved to column
  a_r6_col_before_cas: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && rfsh_n) |-> mux_col);

  // R8: ROM enable only for memory reads
  a_r8_rom_read_only: assert property (@(posedge clk) disable iff (rst)
    !rom_en_n |-> (!mreq_n && !rd_n));

  // R9: read buffer never during a write, never with ROM
  a_r9_buf_not_on_write: assert property (@(posedge clk) disable iff (rst)
    !rdbuf_en_n |-> (wr_n && rom_en_n));

  // R2: once cleared, boot reads no longer go to ROM
  a_r2_clear_sticks: assert property (@(posedge clk) disable iff (rst)
    boot_clear |=> rom_en_n);

  // R11: all strobes inactive without a request
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    mreq_n |-> (ras_n && cas_n && !mux_col && rom_en_n && rdbuf_en_n));

  // R10: write enable tracks the CPU strobe
  a_r10_we_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> !we_n);
endmodule

bind dram_seq_ctrl dram_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .boot_clear (boot_clear),
  .mreq_n     (mreq_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .rfsh_n     (rfsh_n),
  .dram_addr  (dram_addr),
  .mux_col    (mux_col),
  .ramsel_n   (ramsel_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .rom_en_n   (rom_en_n),
  .rdbuf_en_n (rdbuf_en_n)
);

// File: tb/sim_dram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_dram_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_clear = 1'b0;
  logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  dram_addr;
  logic        mux_col, ramsel_n, ras_n, cas_n, we_n, rom_en_n, rdbuf_en_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dram_seq_ctrl u0 (
    .clk(clk), .rst(rst), .boot_clear(boot_clear), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .cpu_addr(cpu_addr),
    .dram_addr(dram_addr), .mux_col(mux_col), .ramsel_n(ramsel_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .rom_en_n(rom_en_n),
    .rdbuf_en_n(rdbuf_en_n)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive a bus state just after a falling edge, then settle.
  task automatic bus(input logic mq, input logic rd, input logic wr,
                     input logic rf, input logic [15:0] a);
    @(negedge clk);
    mreq_n = mq; rd_n = rd; wr_n = wr; rfsh_n = rf; cpu_addr = a;
    #1;
  endtask

  task automatic edge1;
    @(posedge clk); #1;
  endtask

  task automatic idle_chk(input string tag);
    bus(1, 1, 1, 1, 16'h0000);
    chk({tag, " R11 ras"}, ras_n, 1);
    chk({tag, " R11 cas"}, cas_n, 1);
    chk({tag, " R11 mux"}, mux_col, 0);
    chk({tag, " R11 rom"}, rom_en_n, 1);
    chk({tag, " R11 buf"}, rdbuf_en_n, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R3 idle ramsel", ramsel_n, 1);
    bus(0, 0, 1, 1, 16'h1234);
    chk("R1 boot rom", rom_en_n, 0);
    chk("R1 boot buf", rdbuf_en_n, 1);
    chk("R4 boot read ras", ras_n, 1);
    chk("R3 boot read ramsel", ramsel_n, 0);
    edge1; edge1;
    chk("R7 boot read cas", cas_n, 1);
    chk("R1 boot read cas", cas_n, 1);
    idle_chk("reset");
  endtask

  task automatic t_boot_write;
    bus(0, 1, 1, 1, 16'hBEEF);
    chk("R4 boot pre-write ras", ras_n, 1);
    edge1; edge1;
    chk("R7 boot cas waits wr", cas_n, 1);
    bus(0, 1, 0, 1, 16'hBEEF);
    chk("R4 boot write ras", ras_n, 0);
    chk("R7 boot write cas", cas_n, 0);
    chk("R10 we low", we_n, 0);
    chk("R6 boot write col", dram_addr, 16'h00BE);
    chk("R8 no rom on write", rom_en_n, 1);
    idle_chk("bootwr");
    chk("R10 we high", we_n, 1);
  endtask

  task automatic t_clear_midread;
    bus(0, 0, 1, 1, 16'h4321);
    chk("R8 rom before clear", rom_en_n, 0);
    @(negedge clk); boot_clear = 1'b1;
    edge1;
    chk("R2 rom after clear", rom_en_n, 1);
    chk("R9 buf after clear", rdbuf_en_n, 0);
    chk("R4 ras after clear", ras_n, 0);
    @(negedge clk); boot_clear = 1'b0;
    idle_chk("clear");
  endtask

  task automatic t_read;
    bus(0, 0, 1, 1, 16'hA53C);
    chk("R4 read ras", ras_n, 0);
    chk("R6 read row sel", mux_col, 0);
    chk("R6 read row addr", dram_addr, 16'h003C);
    chk("R7 read cas early", cas_n, 1);
    chk("R9 read buf", rdbuf_en_n, 0);
    chk("R2 still cleared rom", rom_en_n, 1);
    edge1;
    chk("R6 col sel tap1", mux_col, 1);
    chk("R6 col addr", dram_addr, 16'h00A5);
    chk("R7 cas not yet", cas_n, 1);
    edge1;
    chk("R7 read cas tap2", cas_n, 0);
    idle_chk("read");
  endtask

  task automatic t_write;
    bus(0, 1, 1, 1, 16'h7E81);
    chk("R4 write ras", ras_n, 0);
    chk("R9 write buf off", rdbuf_en_n, 1);
    edge1; edge1;
    chk("R7 write cas waits", cas_n, 1);
    bus(0, 1, 0, 1, 16'h7E81);
    chk("R7 write cas", cas_n, 0);
    chk("R9 buf off late write", rdbuf_en_n, 1);
    chk("R10 we write", we_n, 0);
    idle_chk("write");
  endtask

  task automatic t_refresh;
    bus(0, 1, 1, 0, 16'hFF5A);
    chk("R4 refresh ras", ras_n, 0);
    chk("R3 refresh ramsel", ramsel_n, 1);
    edge1; edge1; edge1;
    chk("R5 refresh cas", cas_n, 1);
    chk("R5 refresh mux", mux_col, 0);
    chk("R5 refresh addr", dram_addr, 16'h005A);
    idle_chk("refresh");
  endtask

  task automatic t_back_to_back;
    bus(0, 0, 1, 1, 16'hC3E7);
    edge1; edge1;
    chk("R7 b2b read cas", cas_n, 0);
    bus(0, 1, 1, 0, 16'h0011);
    chk("R5 b2b refresh cas", cas_n, 1);
    chk("R5 b2b refresh mux", mux_col, 0);
    chk("R5 b2b refresh addr", dram_addr, 16'h0011);
    edge1;
    bus(0, 0, 1, 1, 16'h9F20);
    chk("R11 restart row", mux_col, 0);
    chk("R11 restart addr", dram_addr, 16'h0020);
    edge1;
    chk("R6 restart col", dram_addr, 16'h009F);
    idle_chk("b2b");
  endtask

  initial begin
    t_reset;
    t_boot_write;
    t_clear_midread;
    t_read;
    t_write;
    t_refresh;
    t_back_to_back;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule